// File: doc/BRIEF.md
# System Clock Source Switch with Failover

This block picks the system clock from one of three sources: an internal RC oscillator, an external crystal oscillator and a PLL output. Software turns the oscillators on and off through a control write port. It requests a source through a select write port. The block moves the system clock to the requested source only after that source reports ready. Until then the request stays pending, and the changeover starts by itself once the ready input rises. A status field shows the source that actually drives the clock. It keeps the old code until the changeover has completed.

The changeover is glitch-free. The select for each source passes through a two-flop synchronizer clocked by that source. The clock gate then opens or closes on that source's falling edge. The controller first waits until the old gate is confirmed closed, then opens the new gate and waits for its acknowledgement.

A monitor running on the internal clock watches the crystal clock. If no crystal edge arrives within a window of `win_len` internal cycles while the monitor is on, a failover takes place. The crystal enable is cleared and a sticky security flag is set, which drives a non-maskable interrupt line. If the crystal fed the system clock, either directly or as the PLL reference, the clock returns to the internal RC source. Disable interlocks stop software from switching off a source that is in use.

The controller runs four named states. HOLD is stable. PEND means a request is waiting for ready. DROP waits for the old gate to close. RAISE waits for the new gate to open. The transitions are:
- HOLD→PEND when the request differs from the status and the target is not ready.
- HOLD→DROP or PEND→DROP when the target is ready.
- PEND→HOLD when the request returns to the status.
- DROP→RAISE when the old gate has closed.
- RAISE→HOLD when the new gate has opened, at which point the status is updated.
- Any state→RAISE toward RC on a crystal failure that affects the system clock.

Top module: `clksw_top`

## Requirements
- R1: After reset, rc_en is 1 and xt_en, pll_en, pll_ref_xt and mon_en are 0. sel_req and sel_stat are both 00, and css_flag and nmi are 0.
- R2: Source codes are 00 for the internal RC, 01 for the crystal and 10 for the PLL, in both sel_req and sel_stat. A select write of 11 is ignored and leaves sel_req unchanged.
- R3: The clock changes over to a requested source only while its ready input is high. A request made while the source is not ready is held in sel_req, and the changeover completes without any further write once ready rises.
- R4: sel_stat keeps the previous code until the changeover is done and then takes the requested code. Once settled, sys_clk runs at the frequency of the source named in sel_stat.
- R5: The control write fields are bit 0 RC enable, bit 1 crystal enable, bit 2 PLL enable, bit 3 PLL reference (1 = crystal, 0 = RC), bit 4 monitor enable, and bit 5 write-one-to-clear of the security flag.
- R6: A write that clears the RC enable is refused while the status is RC, or while the status is PLL with the RC reference. The same rule applies to the crystal enable with the crystal reference.
- R7: While sel_stat is PLL, writes leave pll_en and pll_ref_xt unchanged.
- R8: With the monitor on and the crystal enabled and ready, if no crystal edge is seen for win_len internal cycles, xt_en clears and css_flag and nmi rise. A running crystal causes no failover.
- R9: A crystal failure while the crystal drives the system clock, directly or as the PLL reference, forces sel_req and then sel_stat to 00.
- R10: css_flag stays set until a control write with bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock, also the control clock |
| clk_xt | input | 1 | External crystal clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | Control write data (fields in R5) |
| sel_wr | input | 1 | Source select write strobe |
| sel_wdata | input | 2 | Requested source code |
| win_len | input | WIN_W | Failure window in internal clock cycles |
| rc_rdy | input | 1 | Internal RC ready |
| xt_rdy | input | 1 | Crystal ready |
| pll_rdy | input | 1 | PLL locked |
| rc_en | output | 1 | Internal RC oscillator enable |
| xt_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_ref_xt | output | 1 | PLL reference select, 1 = crystal |
| mon_en | output | 1 | Clock monitor enable |
| sel_req | output | 2 | Requested source |
| sel_stat | output | 2 | Source currently driving sys_clk |
| css_flag | output | 1 | Sticky clock failure flag |
| nmi | output | 1 | Non-maskable interrupt request |
| sys_clk | output | 1 | Gated system clock |

## Verification
The switching function is driven through a sequence of source moves: RC to crystal, crystal to PLL with the crystal as reference, and PLL back to RC. Interleaved control writes try to disable the source in use, disable an unused source, and retarget a running PLL. After each step the status, the enables and the counted frequency of sys_clk are compared. This tells apart a refused write from an accepted one, and a finished changeover from one that stopped partway. A held PLL ready shows the difference between a pending request and a completed one. Stopping the crystal while it drives the clock separates a real failover from the quiet behaviour of a healthy, monitored crystal.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NSRC  = 3;
    localparam int CTL_W = 6;

    // control write field positions
    localparam int B_RC  = 0;
    localparam int B_XT  = 1;
    localparam int B_PLL = 2;
    localparam int B_REF = 3;
    localparam int B_MON = 4;
    localparam int B_CLR = 5;

    typedef enum logic [1:0] {
        SRC_RC  = 2'b00,
        SRC_XT  = 2'b01,
        SRC_PLL = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_PEND,
        ST_DROP,
        ST_RAISE
    } sw_state_e;

    function automatic logic src_uses_xt(src_e s, logic ref_xt);
        return (s == SRC_XT) || ((s == SRC_PLL) && ref_xt);
    endfunction

    function automatic logic src_uses_rc(src_e s, logic ref_xt);
        return (s == SRC_RC) || ((s == SRC_PLL) && !ref_xt);
    endfunction

    function automatic logic [NSRC-1:0] src_onehot(src_e s);
        return NSRC'(1) << s;
    endfunction

endpackage

// File: rtl/clksw_gate.sv
// Glitch-free gate cell for one clock source.
module clksw_gate #(
    parameter int   SYNC   = 2,
    parameter logic RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic ctl_clk,
    input  logic rst_n,
    input  logic kill,
    input  logic sel,
    output logic gate_on,
    output logic ack
);
    logic [SYNC-1:0] sel_sync;
    logic [SYNC-1:0] ack_sync;
    logic            gate_q;

    // select brought into the source domain
    always_ff @(posedge src_clk or negedge rst_n or posedge kill) begin
        if (!rst_n)
            sel_sync <= {SYNC{RST_ON}};
        else if (kill)
            sel_sync <= '0;
        else
            sel_sync <= {sel_sync[SYNC-2:0], sel};
    end

    // gate changes only while the source clock is low
    always_ff @(negedge src_clk or negedge rst_n or posedge kill) begin
        if (!rst_n)
            gate_q <= RST_ON;
        else if (kill)
            gate_q <= 1'b0;
        else
            gate_q <= sel_sync[SYNC-1];
    end

    // gate state reported back to the control domain
    always_ff @(posedge ctl_clk or negedge rst_n) begin
        if (!rst_n)
            ack_sync <= {SYNC{RST_ON}};
        else
            ack_sync <= {ack_sync[SYNC-2:0], gate_q};
    end

    assign gate_on = gate_q;
    assign ack     = ack_sync[SYNC-1];
endmodule

// File: rtl/clksw_mon.sv
// Crystal activity monitor, counts in the internal clock domain.
module clksw_mon #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xt_clk,
    input  logic             arm,
    input  logic [WIN_W-1:0] win_len,
    output logic             fail
);
    logic             tgl;
    logic [2:0]       tsync;
    logic [WIN_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge xt_clk or negedge rst_n) begin
        if (!rst_n) tgl <= 1'b0;
        else        tgl <= ~tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tsync <= '0;
        else        tsync <= {tsync[1:0], tgl};
    end

    assign seen = tsync[2] ^ tsync[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            fail <= 1'b0;
        end else begin
            if (!arm || seen)
                cnt <= '0;
            else if (cnt != win_len)
                cnt <= cnt + WIN_W'(1);
            fail <= arm && !seen && (win_len != '0)
                    && (cnt == win_len - WIN_W'(1));
        end
    end
endmodule

// File: rtl/clksw_ctl.sv
// Oscillator enables, request register, interlocks and security flag.
module clksw_ctl
    import clksw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  src_e             stat,
    input  logic             xt_busy,
    input  logic             fail,
    output logic             rc_on,
    output logic             xt_on,
    output logic             pll_on,
    output logic             pll_ref,
    output logic             mon_on,
    output logic             flag,
    output src_e             req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rc_on   <= 1'b1;
            xt_on   <= 1'b0;
            pll_on  <= 1'b0;
            pll_ref <= 1'b0;
            mon_on  <= 1'b0;
            flag    <= 1'b0;
            req     <= SRC_RC;
        end else begin
            if (ctl_wr) begin
                if (ctl_wdata[B_RC] || !src_uses_rc(stat, pll_ref))
                    rc_on <= ctl_wdata[B_RC];
                if (ctl_wdata[B_XT] || !src_uses_xt(stat, pll_ref))
                    xt_on <= ctl_wdata[B_XT];
                if (stat != SRC_PLL) begin
                    pll_on  <= ctl_wdata[B_PLL];
                    pll_ref <= ctl_wdata[B_REF];
                end
                mon_on <= ctl_wdata[B_MON];
            end
            if (sel_wr && (sel_wdata != 2'b11))
                req <= src_e'(sel_wdata);
            if (fail) begin
                xt_on <= 1'b0;
                flag  <= 1'b1;
                if (xt_busy)
                    req <= SRC_RC;
            end else if (ctl_wr && ctl_wdata[B_CLR]) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clksw_fsm.sv
// Changeover sequencer: HOLD, PEND, DROP, RAISE.
module clksw_fsm
    import clksw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            req,
    input  logic [NSRC-1:0] rdy,
    input  logic [NSRC-1:0] ack,
    input  logic            pll_ref,
    input  logic            fail,
    output src_e            stat,
    output logic [NSRC-1:0] gate_sel,
    output logic            xt_busy
);
    sw_state_e st, st_n;
    src_e      tgt, tgt_n, stat_n;
    logic      fall;

    assign xt_busy = src_uses_xt(stat, pll_ref)
                   || (((st == ST_DROP) || (st == ST_RAISE)) && src_uses_xt(tgt, pll_ref));
    assign fall    = fail && xt_busy;

    always_comb begin
        st_n   = st;
        tgt_n  = tgt;
        stat_n = stat;
        unique case (st)
            ST_HOLD: begin
                if (req != stat) begin
                    if (rdy[req]) begin
                        st_n  = ST_DROP;
                        tgt_n = req;
                    end else begin
                        st_n = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (req == stat) begin
                    st_n = ST_HOLD;
                end else if (rdy[req]) begin
                    st_n  = ST_DROP;
                    tgt_n = req;
                end
            end
            ST_DROP: begin
                if (!ack[stat])
                    st_n = ST_RAISE;
            end
            ST_RAISE: begin
                if (ack[tgt]) begin
                    st_n   = ST_HOLD;
                    stat_n = tgt;
                end
            end
            default: st_n = ST_HOLD;
        endcase
        if (fall) begin
            st_n   = ST_RAISE;
            tgt_n  = SRC_RC;
            stat_n = stat;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_HOLD;
            tgt  <= SRC_RC;
            stat <= SRC_RC;
        end else begin
            st   <= st_n;
            tgt  <= tgt_n;
            stat <= stat_n;
        end
    end

    // registered gate selects, free of combinational glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_sel <= src_onehot(SRC_RC);
        end else begin
            unique case (st_n)
                ST_HOLD, ST_PEND: gate_sel <= src_onehot(stat_n);
                ST_DROP:          gate_sel <= '0;
                ST_RAISE:         gate_sel <= src_onehot(tgt_n);
                default:          gate_sel <= '0;
            endcase
        end
    end
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int WIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_rc,
    input  logic             clk_xt,
    input  logic             clk_pll,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic [WIN_W-1:0] win_len,
    input  logic             rc_rdy,
    input  logic             xt_rdy,
    input  logic             pll_rdy,
    output logic             rc_en,
    output logic             xt_en,
    output logic             pll_en,
    output logic             pll_ref_xt,
    output logic             mon_en,
    output logic [1:0]       sel_req,
    output logic [1:0]       sel_stat,
    output logic             css_flag,
    output logic             nmi,
    output logic             sys_clk
);
    src_e            req, stat;
    logic            xt_busy, fail;
    logic [NSRC-1:0] clk_vec, kill_vec, rdy_vec, ack_vec, gate_sel, gate_vec;

    clksw_ctl u_ctl (
        .clk       (clk_rc),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .stat      (stat),
        .xt_busy   (xt_busy),
        .fail      (fail),
        .rc_on     (rc_en),
        .xt_on     (xt_en),
        .pll_on    (pll_en),
        .pll_ref   (pll_ref_xt),
        .mon_on    (mon_en),
        .flag      (css_flag),
        .req       (req)
    );

    clksw_mon #(.WIN_W(WIN_W)) u_mon (
        .clk     (clk_rc),
        .rst_n   (rst_n),
        .xt_clk  (clk_xt),
        .arm     (mon_en && xt_en && xt_rdy),
        .win_len (win_len),
        .fail    (fail)
    );

    assign rdy_vec  = {pll_rdy, xt_rdy, rc_rdy};
    assign clk_vec  = {clk_pll, clk_xt, clk_rc};
    assign kill_vec = {(!pll_en || (pll_ref_xt && !xt_en)), !xt_en, !rc_en};

    clksw_fsm u_fsm (
        .clk      (clk_rc),
        .rst_n    (rst_n),
        .req      (req),
        .rdy      (rdy_vec),
        .ack      (ack_vec),
        .pll_ref  (pll_ref_xt),
        .fail     (fail),
        .stat     (stat),
        .gate_sel (gate_sel),
        .xt_busy  (xt_busy)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        clksw_gate #(
            .SYNC   (SYNC_STAGES),
            .RST_ON ((g == 0) ? 1'b1 : 1'b0)
        ) u_gate (
            .src_clk (clk_vec[g]),
            .ctl_clk (clk_rc),
            .rst_n   (rst_n),
            .kill    (kill_vec[g]),
            .sel     (gate_sel[g]),
            .gate_on (gate_vec[g]),
            .ack     (ack_vec[g])
        );
    end

    assign sys_clk  = |(clk_vec & gate_vec);
    assign sel_req  = req;
    assign sel_stat = stat;
    assign nmi      = css_flag;
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk (
    input logic       clk_rc,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [5:0] ctl_wdata,
    input logic       sel_wr,
    input logic [1:0] sel_wdata,
    input logic       rc_en,
    input logic       xt_en,
    input logic       pll_en,
    input logic       pll_ref_xt,
    input logic [1:0] sel_req,
    input logic [1:0] sel_stat,
    input logic       css_flag
);
    AST_CODE_LEGAL: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (sel_stat != 2'b11) && (sel_req != 2'b11)); // R2

    AST_SEL11_IGNORED: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (sel_wr && sel_wdata == 2'b11) |=> (sel_req == $past(sel_req)) || $rose(css_flag)); // R2

    AST_STAT_ENABLED: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (sel_stat != $past(sel_stat)) |->
            ((sel_stat == 2'b00) && rc_en) || ((sel_stat == 2'b01) && xt_en)
            || ((sel_stat == 2'b10) && pll_en)); // R3

    AST_RC_HELD: assert property (@(posedge clk_rc) disable iff (!rst_n)
        $fell(rc_en) |-> ($past(sel_stat) != 2'b00)); // R6

    AST_XT_HELD: assert property (@(posedge clk_rc) disable iff (!rst_n)
        ($fell(xt_en) && $past(sel_stat) == 2'b01) |-> css_flag); // R6

    AST_PLL_FROZEN: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (sel_stat == 2'b10) |=> $stable(pll_en) && $stable(pll_ref_xt)); // R7

    AST_FAIL_DROPS_XT: assert property (@(posedge clk_rc) disable iff (!rst_n)
        $rose(css_flag) |-> !xt_en); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (css_flag && !(ctl_wr && ctl_wdata[5])) |=> css_flag); // R10
endmodule

bind clksw_top clksw_chk u_chk (.*);

// File: tb/sim_clksw_top.sv
module sim_clksw_top;
    logic       clk = 1'b0, clk_xt = 1'b0, clk_pll = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, sel_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [1:0] sel_wdata = '0;
    logic [7:0] win_len = 8'd16;
    logic       rc_rdy, xt_rdy, pll_rdy;
    logic       rc_en, xt_en, pll_en, pll_ref_xt, mon_en, css_flag, nmi, sys_clk;
    logic [1:0] sel_req, sel_stat;
    logic       xt_run = 1'b1, pll_hold = 1'b0;
    logic [9:0] rc_sh = '0, xt_sh = '0, pll_sh = '0;
    int         checks = 0, errors = 0, edge_cnt = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;
    always begin #10; if (xt_run) clk_xt = ~clk_xt; end
    always #6 clk_pll = ~clk_pll;

    // oscillator model: ready ten cycles after enable
    always @(posedge clk) begin
        rc_sh  <= {rc_sh[8:0], rc_en};
        xt_sh  <= {xt_sh[8:0], xt_en};
        pll_sh <= {pll_sh[8:0], pll_en};
    end
    assign rc_rdy  = rc_sh[9] & rc_en;
    assign xt_rdy  = xt_sh[9] & xt_en;
    assign pll_rdy = pll_sh[9] & pll_en & !pll_hold;

    always @(posedge sys_clk) edge_cnt <= edge_cnt + 1;

    clksw_top u0 (
        .clk_rc(clk), .clk_xt(clk_xt), .clk_pll(clk_pll), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .win_len(win_len), .rc_rdy(rc_rdy), .xt_rdy(xt_rdy), .pll_rdy(pll_rdy),
        .rc_en(rc_en), .xt_en(xt_en), .pll_en(pll_en), .pll_ref_xt(pll_ref_xt),
        .mon_en(mon_en), .sel_req(sel_req), .sel_stat(sel_stat),
        .css_flag(css_flag), .nmi(nmi), .sys_clk(sys_clk)
    );

    // {op(1=ctl,0=sel), data[5:0], exp stat[1:0], exp {ref,pll,xt,rc}}
    localparam int NVEC = 11;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 6'b000011, 2'b00, 4'b0011},  // enable crystal
        {1'b0, 6'b000001, 2'b01, 4'b0011},  // R4 RC -> crystal
        {1'b1, 6'b000010, 2'b01, 4'b0010},  // R6 unused RC may stop
        {1'b1, 6'b000000, 2'b01, 4'b0010},  // R6 crystal in use kept
        {1'b1, 6'b001111, 2'b01, 4'b1111},  // R5 PLL on, crystal reference
        {1'b0, 6'b000010, 2'b10, 4'b1111},  // R4 crystal -> PLL
        {1'b1, 6'b001101, 2'b10, 4'b1111},  // R6 crystal as PLL reference kept
        {1'b1, 6'b000011, 2'b10, 4'b1111},  // R7 PLL fields frozen
        {1'b0, 6'b000000, 2'b00, 4'b1111},  // R4 PLL -> RC
        {1'b1, 6'b000011, 2'b00, 4'b0011},  // R7 PLL off once idle
        {1'b0, 6'b000011, 2'b00, 4'b0011}   // R2 code 11 ignored
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [5:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_sel(input logic [1:0] d);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = d;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    function automatic int exp_rate(input logic [1:0] s);
        return (s == 2'b00) ? 100 : (s == 2'b01) ? 40 : 67;
    endfunction

    task automatic rate_chk(input logic [1:0] s, input string tag);
        int c0, d;
        c0 = edge_cnt;
        #800;
        d = edge_cnt - c0;
        chk((d >= exp_rate(s) - 2) && (d <= exp_rate(s) + 2), tag, d, exp_rate(s));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rc_en == 1'b1, "R1 rc_en", rc_en, 1);
        chk({xt_en, pll_en, pll_ref_xt, mon_en} == 4'b0, "R1 other enables",
            {xt_en, pll_en, pll_ref_xt, mon_en}, 0);
        chk(sel_req == 2'b00 && sel_stat == 2'b00, "R1 req/stat", {sel_req, sel_stat}, 0);
        chk(css_flag == 1'b0 && nmi == 1'b0, "R1 flag/nmi", {css_flag, nmi}, 0);
        settle();
        rate_chk(2'b00, "R4 reset clock rate");

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][12]) wr_ctl(VEC[i][11:6]);
            else            wr_sel(VEC[i][7:6]);
            settle();
            chk(sel_stat == VEC[i][5:4], $sformatf("R4 vec%0d stat", i), sel_stat, VEC[i][5:4]);
            chk(sel_req == VEC[i][5:4], $sformatf("R2 vec%0d req", i), sel_req, VEC[i][5:4]);
            chk({pll_ref_xt, pll_en, xt_en, rc_en} == VEC[i][3:0],
                $sformatf("R6 R7 vec%0d enables", i), {pll_ref_xt, pll_en, xt_en, rc_en}, VEC[i][3:0]);
            rate_chk(VEC[i][5:4], $sformatf("R4 vec%0d rate", i));
        end

        // R3 pending request held until PLL locks
        pll_hold = 1'b1;
        wr_ctl(6'b000111);
        wr_sel(2'b10);
        settle();
        chk(sel_stat == 2'b00, "R3 pending stat", sel_stat, 0);
        chk(sel_req == 2'b10, "R3 pending req", sel_req, 2);
        rate_chk(2'b00, "R3 pending rate");
        pll_hold = 1'b0;
        settle();
        chk(sel_stat == 2'b10, "R3 deferred switch", sel_stat, 2);
        rate_chk(2'b10, "R3 deferred rate");
        wr_sel(2'b00);
        settle();
        chk(sel_stat == 2'b00, "R4 back to RC", sel_stat, 0);
        wr_ctl(6'b000011);
        settle();

        // R8 healthy crystal under monitor, then failure
        wr_ctl(6'b010011);
        wr_sel(2'b01);
        settle();
        chk(sel_stat == 2'b01, "R8 monitored crystal selected", sel_stat, 1);
        chk(css_flag == 1'b0, "R8 no false failover", css_flag, 0);
        xt_run = 1'b0;
        settle();
        chk(css_flag == 1'b1 && nmi == 1'b1, "R8 flag and nmi", {css_flag, nmi}, 3);
        chk(xt_en == 1'b0, "R8 crystal disabled", xt_en, 0);
        chk(sel_req == 2'b00, "R9 request forced", sel_req, 0);
        chk(sel_stat == 2'b00, "R9 status back to RC", sel_stat, 0);
        rate_chk(2'b00, "R9 RC rate after failover");
        wr_ctl(6'b000001);
        repeat (5) @(negedge clk);
        chk(css_flag == 1'b1, "R10 flag sticky", css_flag, 1);
        wr_ctl(6'b100001);
        repeat (2) @(negedge clk);
        chk(css_flag == 1'b0 && nmi == 1'b0, "R10 flag cleared", {css_flag, nmi}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule